// File: doc/BRIEF.md
# TDMA Slot Sequencer

This block divides time into a repeating ring of slots. Each slot opens with a scheduling window of programmable length, the start phase. The rest of the slot's own programmed duration is the end phase. The sequencer then moves on to the next slot and wraps after the last one. Two countdown timers drive it. One counts out the scheduling window and the other counts out the whole slot. The timer expiries are the only events that move the slot position and the slot index.

The surrounding logic watches `slot_idx` and `phase_end`. When the scheduling window of a slot expires, the block issues a one-cycle `dispatch` pulse that carries the slot number, and work for that slot can be launched. A small configuration port writes the window length and the per-slot durations into holding registers. The timers load from these holding registers only when a new slot begins, so a slot that is in progress keeps its timing.

Top module: `tdma_slot_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `slot_idx` is 0, `phase_end` is 0 (start phase) and `dispatch` is 0.
- R2: Every slot begins in the start phase, which lasts S cycles. S is the window length in force when the slot began, and a programmed value of 0 is treated as 1. `phase_end` then becomes 1 (end phase) for the rest of the slot.
- R3: In the first cycle of each end phase, `dispatch` is 1 for exactly one cycle and `dispatch_idx` equals the current `slot_idx`. At all other times `dispatch` is 0.
- R4: A slot whose effective duration is D lasts exactly D cycles from its first start-phase cycle. After that, `slot_idx` advances by one and the start phase begins again.
- R5: After slot NUM_SLOTS-1, `slot_idx` wraps to 0.
- R6: If a slot's programmed duration is not greater than S, the slot lasts S+1 cycles, so its end phase is exactly one cycle long.
- R7: A configuration write is made by asserting `cfg_we`. With `cfg_sel_sched`=1 it sets the window length; with `cfg_sel_sched`=0 it sets the duration of slot `cfg_idx`. A write affects neither the slot in progress nor the slot that starts on the same clock edge. It is first used by a slot that begins at a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel_sched | input | 1 | 1: write the window length, 0: write a slot duration |
| cfg_idx | input | IDX_W | Slot selected by a duration write |
| cfg_data | input | DUR_W | Value written, in cycles |
| slot_idx | output | IDX_W | Current slot |
| phase_end | output | 1 | 0 in the start phase, 1 in the end phase |
| dispatch | output | 1 | One-cycle pulse when the scheduling window expires |
| dispatch_idx | output | IDX_W | Slot carried by the dispatch pulse |

## Verification
All outputs are registered. A timer expiry seen in cycle c shows up as a new phase, a new slot or a dispatch pulse in cycle c+1. A configuration write sampled at an edge is first used by a slot that begins at a later edge. The bench's reference model counts cycles since each slot boundary and updates on the same rising edge as the design. It applies the write only after it has evaluated the boundary. Outputs are compared at every falling edge, so each expected value is checked in the exact cycle it falls due.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

  typedef enum logic {
    PH_START = 1'b0,
    PH_END   = 1'b1
  } phase_e;

  // Scheduling window length actually used: zero counts as one cycle.
  function automatic int unsigned eff_sched(input int unsigned s);
    return (s == 0) ? 1 : s;
  endfunction

  // Slot length actually used: always at least one cycle past the window.
  function automatic int unsigned eff_slot(input int unsigned d, input int unsigned s);
    int unsigned w;
    w = eff_sched(s);
    return (d > w) ? d : w + 1;
  endfunction

endpackage

// File: rtl/tdma_cfg_regs.sv
module tdma_cfg_regs #(
  parameter int NUM_SLOTS = 4,
  parameter int DUR_W     = 16,
  parameter int DEF_SCHED = 4,
  parameter int DEF_SLOT  = 10,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic                              sel_sched,
  input  logic [IDX_W-1:0]                  idx,
  input  logic [DUR_W-1:0]                  data,
  output logic [DUR_W-1:0]                  sched_len,
  output logic [NUM_SLOTS-1:0][DUR_W-1:0]   slot_len
);

  always_ff @(posedge clk) begin
    if (!rst_n)                sched_len <= DUR_W'(DEF_SCHED);
    else if (we && sel_sched)  sched_len <= data;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = we && !sel_sched && (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   slot_len[g] <= DUR_W'(DEF_SLOT);
      else if (hit) slot_len[g] <= data;
    end
  end

endmodule

// File: rtl/tdma_countdown.sv
module tdma_countdown #(
  parameter int W       = 17,
  parameter int RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         en,
  output logic         expire
);

  logic [W-1:0] cnt;

  assign expire = en && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= W'(RST_VAL);
    else if (load)               cnt <= ld_val;
    else if (en && cnt > W'(1))  cnt <= cnt - W'(1);
  end

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0); // R2

endmodule

// File: rtl/tdma_slot_seq.sv
module tdma_slot_seq #(
  parameter int NUM_SLOTS = 4,
  parameter int DUR_W     = 16,
  parameter int DEF_SCHED = 4,
  parameter int DEF_SLOT  = 10,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel_sched,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [DUR_W-1:0] cfg_data,
  output logic [IDX_W-1:0] slot_idx,
  output logic             phase_end,
  output logic             dispatch,
  output logic [IDX_W-1:0] dispatch_idx
);
  import tdma_pkg::*;

  localparam int CW = DUR_W + 1;
  localparam int LAST = NUM_SLOTS - 1;
  localparam int RST_S = eff_sched(DEF_SCHED);
  localparam int RST_D = eff_slot(DEF_SLOT, DEF_SCHED);

  logic [DUR_W-1:0]                sched_len;
  logic [NUM_SLOTS-1:0][DUR_W-1:0] slot_len;
  logic [IDX_W-1:0]                slot_q, nxt_idx;
  phase_e                          phase_q;
  logic                            disp_q;
  logic                            sched_evt, slot_evt;
  logic [CW-1:0]                   sched_ld, slot_ld;

  tdma_cfg_regs #(
    .NUM_SLOTS(NUM_SLOTS), .DUR_W(DUR_W),
    .DEF_SCHED(DEF_SCHED), .DEF_SLOT(DEF_SLOT)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel_sched(cfg_sel_sched),
    .idx(cfg_idx), .data(cfg_data), .sched_len(sched_len), .slot_len(slot_len)
  );

  assign nxt_idx  = (slot_q == IDX_W'(LAST)) ? '0 : slot_q + IDX_W'(1);
  assign sched_ld = CW'(eff_sched(int'(sched_len)));
  assign slot_ld  = CW'(eff_slot(int'(slot_len[nxt_idx]), int'(sched_len)));

  tdma_countdown #(.W(CW), .RST_VAL(RST_S)) sched_tmr_i (
    .clk(clk), .rst_n(rst_n), .load(slot_evt), .ld_val(sched_ld),
    .en(phase_q == PH_START), .expire(sched_evt)
  );

  tdma_countdown #(.W(CW), .RST_VAL(RST_D)) slot_tmr_i (
    .clk(clk), .rst_n(rst_n), .load(slot_evt), .ld_val(slot_ld),
    .en(1'b1), .expire(slot_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q  <= '0;
      phase_q <= PH_START;
      disp_q  <= 1'b0;
    end else begin
      disp_q <= 1'b0;
      if (slot_evt) begin
        slot_q  <= nxt_idx;
        phase_q <= PH_START;
      end else if (sched_evt) begin
        phase_q <= PH_END;
        disp_q  <= 1'b1;
      end
    end
  end

  assign slot_idx     = slot_q;
  assign phase_end    = (phase_q == PH_END);
  assign dispatch     = disp_q;
  assign dispatch_idx = slot_q;

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sched_evt && slot_evt)); // R6
  AST_SLOT_END_IN_END_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_evt |-> phase_end); // R6
  AST_DISPATCH_WITH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_end) |-> dispatch); // R3
  AST_DISPATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> !dispatch); // R3
  AST_ADVANCE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_end) |-> slot_idx == (($past(slot_idx) == IDX_W'(LAST)) ? '0 : $past(slot_idx) + IDX_W'(1))); // R5
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(phase_end) |-> $stable(slot_idx)); // R4
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idx <= IDX_W'(LAST)); // R4

endmodule

// File: tb/tdma_slot_seq_tb.sv
module tdma_slot_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int DW = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel_sched = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [DW-1:0] cfg_data = '0;
  logic [IW-1:0] slot_idx, dispatch_idx;
  logic phase_end, dispatch;

  int checks = 0, errors = 0, cyc = 0;

  // reference model state
  int m_slot, m_cnt, m_s, m_d, m_ph, m_disp;
  int sh_sched;
  int sh_dur[NS];
  bit m_pend, m_clamp;

  tdma_slot_seq #(.NUM_SLOTS(NS), .DUR_W(DW), .DEF_SCHED(4), .DEF_SLOT(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel_sched(cfg_sel_sched),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .slot_idx(slot_idx),
    .phase_end(phase_end), .dispatch(dispatch), .dispatch_idx(dispatch_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_slot = 0; m_cnt = 0; m_ph = 0; m_disp = 0;
      sh_sched = 4;
      for (int i = 0; i < NS; i++) sh_dur[i] = 10;
      m_s = 4; m_d = 10; m_pend = 0; m_clamp = 0;
    end else begin
      m_cnt++;
      m_disp = 0;
      if (m_cnt == m_d) begin
        m_slot = (m_slot + 1) % NS;
        m_cnt = 0; m_ph = 0;
        m_s = (sh_sched == 0) ? 1 : sh_sched;
        m_clamp = (sh_dur[m_slot] <= m_s);
        m_d = m_clamp ? m_s + 1 : sh_dur[m_slot];
        m_pend = 0;
      end else if (m_cnt == m_s) begin
        m_ph = 1; m_disp = 1;
      end
      if (cfg_we) begin
        if (cfg_sel_sched) sh_sched = int'(cfg_data);
        else sh_dur[cfg_idx] = int'(cfg_data);
        m_pend = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check((m_slot == 0 && m_cnt == 0 && cyc > 12) ? "R5 slot" : "R4 slot", int'(slot_idx), m_slot);
      check(m_pend ? "R7 phase" : (m_clamp ? "R6 phase" : "R2 phase"), int'(phase_end), m_ph);
      check("R3 dispatch", int'(dispatch), m_disp);
      if (m_disp) check("R3 dispatch_idx", int'(dispatch_idx), m_slot);
    end
  end

  task automatic cfg_write(input bit sel, input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel_sched = sel; cfg_idx = IW'(idx); cfg_data = DW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset slot", int'(slot_idx), 0);
    check("R1 reset phase", int'(phase_end), 0);
    check("R1 reset dispatch", int'(dispatch), 0);
    rst_n = 1'b1;
    repeat (47) @(negedge clk);
    cfg_write(1'b1, 0, 3);
    cfg_write(1'b0, 1, 2);
    cfg_write(1'b0, 2, 20);
    cfg_write(1'b0, 3, 7);
    repeat (90) @(negedge clk);
    cfg_write(1'b1, 0, 0);
    cfg_write(1'b0, 0, 1);
    repeat (23) @(negedge clk);
    cfg_write(1'b0, 1, 3);
    repeat (70) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule